// File: doc/BRIEF.md
# Prescaled 16-bit Countdown Timer

This block is a 16-bit timer that counts down from a programmable start value. A power-of-two prescaler paces it. The host stores a start value in the load register, then writes the control register. That write carries the prescaler enable and a 4-bit divide code, and it also starts the countdown.

Each prescaler tick lowers the count by one. When the count would reach zero, it is refilled from the load register and a one-cycle expiry pulse is raised. The current count can be read at any time through a read-only value register.

Access goes through a plain register port:
- a write strobe with its own word address and data;
- an independent read address with combinational read data.

Top module: `ptmr_top`

## Requirements
- R1: After reset, every register reads 0 (control, load, value, and the unused word 3), and `expire_o` is low.
- R2: A write to the control register (word 0) copies the load value into the count and restarts the prescaler phase. With divide ratio D, the first decrement is visible D cycles after that write edge.
- R3: Divide code n in control bits 5:2 sets the ratio. For codes 0 to 12 the count steps once every 2^(n+1) clock cycles, so code 11 gives 4096 and code 12 gives 8192.
- R4: Divide codes 13, 14 and 15 stop the timer, and the count holds its value.
- R5: When control bit 15 is 0 the prescaler is disabled and the count holds its value.
- R6: A tick that finds the count at 1 or 0 loads the count from the load register instead of decrementing. `expire_o` is high for exactly the one cycle that follows this reload.
- R7: Writing the load register (word 1) does not change the running count. The next reload uses the most recently written load value.
- R8: The value register (word 2) is read-only. Writing it changes neither the count nor the timing.
- R9: Read-back format:
  - control returns bit 15 and bits 5:2;
  - load returns bits 15:0;
  - value returns the count in bits 15:0;
  - every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| waddr_i | input | 2 | Write word address (0 control, 1 load, 2 value, 3 unused) |
| wdata_i | input | 32 | Write data |
| raddr_i | input | 2 | Read word address |
| rdata_o | output | 32 | Combinational read data |
| expire_o | output | 1 | One-cycle pulse on reload |

## Verification
The hardest situations to reach are the two longest divide ratios and the reload taking a load value that changed after the start. The first needs thousands of idle cycles before one observable step. The scoreboard driver therefore computes the exact cycle of each step and expiry from the write edge, and queues only those few samples. The monitor compares the value register and `expire_o` at precisely those cycles. For the reload case, the load register is rewritten one cycle after the start, so the reload must show the new value.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_VALUE = 2'd2,
    REG_SPARE = 2'd3
  } reg_addr_e;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned EN_BIT   = 15;
  localparam int unsigned SEL_LSB  = 2;
  localparam int unsigned MAX_CODE = 12;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CNT_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    raddr_i,
  input  logic [CW-1:0] count_i,
  output logic [DW-1:0] rdata_o,
  output logic          en_o,
  output logic [SW-1:0] sel_o,
  output logic [CW-1:0] load_o,
  output logic          restart_o
);
  localparam int unsigned SEL_MSB = SEL_LSB + SW - 1;

  logic wr_ctrl, wr_load;
  logic unused_wdata;

  assign wr_ctrl   = wr_en_i && (reg_addr_e'(waddr_i) == REG_CTRL);
  assign wr_load   = wr_en_i && (reg_addr_e'(waddr_i) == REG_LOAD);
  assign restart_o = wr_ctrl;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      sel_o  <= '0;
      load_o <= '0;
    end else begin
      if (wr_ctrl) begin
        en_o  <= wdata_i[EN_BIT];
        sel_o <= wdata_i[SEL_MSB:SEL_LSB];
      end
      if (wr_load) load_o <= wdata_i[CW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(raddr_i))
      REG_CTRL: begin
        rdata_o[EN_BIT]          = en_o;
        rdata_o[SEL_MSB:SEL_LSB] = sel_o;
      end
      REG_LOAD:  rdata_o[CW-1:0] = load_o;
      REG_VALUE: rdata_o[CW-1:0] = count_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
#(
  parameter int unsigned SW   = SEL_W,
  parameter int unsigned MAXC = MAX_CODE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          en_i,
  input  logic [SW-1:0] sel_i,
  output logic          tick_o
);
  localparam int unsigned PH_W = MAXC + 1;

  logic [PH_W-1:0] phase_q, limit;
  logic            active;

  // ratio-1 = 2^(sel+1)-1 : ones in bits 0..sel
  always_comb begin
    for (int j = 0; j < PH_W; j++) limit[j] = (j <= int'(sel_i));
  end

  assign active = en_i && (int'(sel_i) <= int'(MAXC));
  assign tick_o = active && !restart_i && (phase_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   phase_q <= '0;
    else if (restart_i || !active) phase_q <= '0;
    else if (phase_q == limit)     phase_q <= '0;
    else                           phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
  import ptmr_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] load_i,
  output logic [CW-1:0] count_o,
  output logic          expire_o
);
  logic at_end;
  assign at_end = (count_o <= CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o  <= '0;
      expire_o <= 1'b0;
    end else if (restart_i) begin
      count_o  <= load_i;
      expire_o <= 1'b0;
    end else if (tick_i) begin
      count_o  <= at_end ? load_i : count_o - 1'b1;
      expire_o <= at_end;
    end else begin
      expire_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned CW   = CNT_W,
  parameter int unsigned SW   = SEL_W,
  parameter int unsigned MAXC = MAX_CODE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          expire_o
);
  logic          en_q, restart, tick;
  logic [SW-1:0] sel_q;
  logic [CW-1:0] load_q, count_q;

  ptmr_regs #(.DW(DW), .CW(CW), .SW(SW)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .waddr_i, .wdata_i, .raddr_i,
    .count_i(count_q), .rdata_o, .en_o(en_q), .sel_o(sel_q),
    .load_o(load_q), .restart_o(restart)
  );

  ptmr_prescale #(.SW(SW), .MAXC(MAXC)) i_pre (
    .clk_i, .rst_ni, .restart_i(restart), .en_i(en_q), .sel_i(sel_q),
    .tick_o(tick)
  );

  ptmr_count #(.CW(CW)) i_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .tick_i(tick), .load_i(load_q),
    .count_o(count_q), .expire_o
  );
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
  import ptmr_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned CW   = CNT_W,
  parameter int unsigned SW   = SEL_W,
  parameter int unsigned MAXC = MAX_CODE
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    waddr_i,
  input logic [1:0]    raddr_i,
  input logic [DW-1:0] rdata_o,
  input logic          expire_o,
  input logic          en_q,
  input logic [SW-1:0] sel_q,
  input logic [CW-1:0] load_q,
  input logic [CW-1:0] count_q
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en_i && (waddr_i == 2'd0);

  AST_EXPIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R6
  AST_EXPIRE_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expire_o) |-> count_q == $past(load_q)); // R6
  AST_START_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (count_q == $past(load_q)) && !expire_o); // R2
  AST_OFF_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ctrl && int'(sel_q) > int'(MAXC)) |=> $stable(count_q)); // R4
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ctrl && !en_q) |=> $stable(count_q)); // R5
  AST_VALUE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_i == 2'd2) |-> (rdata_o[DW-1:CW] == '0)); // R9
endmodule

bind ptmr_top ptmr_chk #(.DW(DW), .CW(CW), .SW(SW), .MAXC(MAXC)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .waddr_i(waddr_i),
  .raddr_i(raddr_i), .rdata_o(rdata_o), .expire_o(expire_o),
  .en_q(en_q), .sel_q(sel_q), .load_q(load_q), .count_q(count_q)
);

// File: tb/test_ptmr_top.sv
module test_ptmr_top;
  logic        clk_i = 0, rst_ni = 0, wr_en_i = 0;
  logic [1:0]  waddr_i = 0, raddr_i = 2;
  logic [31:0] wdata_i = 0, rdata_o;
  logic        expire_o;
  int          cyc = 0, checks = 0, errors = 0;

  typedef struct { int at; int cnt; bit exp; string tag; } item_t;
  item_t q[$];

  ptmr_top i_ptmr_top (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic void chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // monitor: compares queued expectations at their cycle
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].at < cyc) begin
      chk(0, {q[0].tag, " missed"}, cyc, q[0].at);
      void'(q.pop_front());
    end
    if (q.size() > 0 && q[0].at == cyc) begin
      chk(rdata_o == 32'(q[0].cnt), q[0].tag, rdata_o, q[0].cnt);
      chk(expire_o == q[0].exp, {q[0].tag, " expire"}, expire_o, q[0].exp);
      void'(q.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int w);
    @(negedge clk_i);
    wr_en_i = 1; waddr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    w = cyc;
    wr_en_i = 0;
  endtask

  task automatic push(int at, int cnt, bit exp, string tag);
    item_t it;
    it.at = at; it.cnt = cnt; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
  endtask

  function automatic logic [31:0] cw(bit en, int sel);
    return (32'(en) << 15) | (32'(sel) << 2);
  endfunction

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i); raddr_i = a;
    #1 chk(rdata_o == exp, tag, rdata_o, exp);
    raddr_i = 2;
  endtask

  initial begin
    #(150000 * 10);
    chk(0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w, w2;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(2'(a), 0, "R1 reset read");
    chk(expire_o == 0, "R1 expire", expire_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 R3 R6: code 0 ratio 2, load 3
    wr(1, 3, w); wr(0, cw(1, 0), w);
    push(w, 3, 0, "R2 start"); push(w+1, 3, 0, "R2 no early step");
    push(w+2, 2, 0, "R3 ratio2"); push(w+4, 1, 0, "R3 ratio2");
    push(w+6, 3, 1, "R6 reload"); push(w+7, 3, 0, "R6 pulse end");
    drain();

    // R3 code 2 ratio 8
    wr(1, 2, w); wr(0, cw(1, 2), w);
    push(w+7, 2, 0, "R3 ratio8 before"); push(w+8, 1, 0, "R3 ratio8");
    push(w+16, 2, 1, "R6 reload r8"); push(w+17, 2, 0, "R6 pulse end r8");
    drain();

    // R3 code 11 ratio 4096
    wr(1, 1, w); wr(0, cw(1, 11), w);
    push(w+4095, 1, 0, "R3 4096 before"); push(w+4096, 1, 1, "R3 4096 reload");
    drain();

    // R3 code 12 ratio 8192
    wr(1, 2, w); wr(0, cw(1, 12), w);
    push(w+8191, 2, 0, "R3 8192 before"); push(w+8192, 1, 0, "R3 8192 step");
    drain();

    // R4 off codes
    for (int c = 13; c < 16; c++) begin
      wr(1, 5, w); wr(0, cw(1, c), w);
      push(w, 5, 0, "R4 off start"); push(w+40, 5, 0, "R4 off hold");
      drain();
    end

    // R5 prescaler disabled
    wr(1, 7, w); wr(0, cw(0, 0), w);
    push(w+30, 7, 0, "R5 disabled hold");
    drain();

    // R8 value register write ignored
    wr(1, 10, w); wr(0, cw(1, 0), w);
    push(w+8, 6, 0, "R8 before"); push(w+18, 1, 0, "R8 running");
    push(w+20, 10, 1, "R8 reload");
    wr(2, 32'h1234, w2);
    drain();

    // R2 restart mid-count
    wr(1, 4, w); wr(0, cw(1, 0), w);
    push(w+2, 3, 0, "R2 first step");
    while (cyc < w + 3) @(posedge clk_i);
    wr(0, cw(1, 0), w2);
    push(w2, 4, 0, "R2 restart copy"); push(w2+1, 4, 0, "R2 restart phase");
    push(w2+2, 3, 0, "R2 restart step");
    drain();

    // R7 load change while running
    wr(1, 2, w); wr(0, cw(1, 0), w);
    wr(1, 5, w2);
    push(w+2, 1, 0, "R7 unaffected"); push(w+4, 5, 1, "R7 new load");
    push(w+5, 5, 0, "R7 pulse end");
    drain();

    // R6 load zero: expire every tick
    wr(1, 0, w); wr(0, cw(1, 0), w);
    push(w, 0, 0, "R6 zero start"); push(w+2, 0, 1, "R6 zero tick");
    push(w+3, 0, 0, "R6 zero gap"); push(w+4, 0, 1, "R6 zero tick2");
    drain();

    // R9 read-back format
    wr(0, 32'hFFFF_FFFF, w);
    rd(0, 32'h0000_803C, "R9 ctrl readback");
    wr(1, 32'hABCD_1234, w);
    rd(1, 32'h0000_1234, "R9 load readback");
    rd(3, 0, "R9 spare word");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule